// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes that pace a small TFT panel fed over an 8-bit byte-serial bus. Every count is kept in byte clocks. A pixel takes two bytes in RGB565 mode and three bytes in RGB888 mode, so a compile-time pixel-format parameter scales every horizontal and vertical dimension. The default geometry is a 320x240 active area. Each line is 336 pixel times long, and each frame is 244 lines long.

The first data byte of a line is placed a fixed number of pixel times after the line starts. An extra external pipeline delay of 3 clocks (RGB565) or 5 clocks (RGB888) is added to that placement. Two blanking lines come before the active lines and two come after them. When `en` is raised, the vertical timer starts first, and the horizontal timer follows a set number of clocks later, so the VS strobe always begins ahead of HS. The raw line and byte counters are brought out so that a downstream pixel fetcher can keep in step with the raster.

The block carries no pixel data, so it has no valid/ready stream. All pins are plain control and status.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is held, and on every cycle in which `en` is low, `hs_n` and `vs_n` are 1, `de` is 0, and `line_idx` and `byte_idx` are 0.
- R2: Once running, `hs_n` falls once every LINE_PIX*B clocks, where B is the bytes per pixel.
- R3: Each HS pulse holds `hs_n` low for HS_PIX*B clocks, starting at byte 0 of a line.
- R4: Within a line, `de` is high from byte LEAD_PIX*B+D through byte LEAD_PIX*B+D+ACT_PIX*B-1. D is the pipeline delay: DLY_565 for RGB565 and DLY_888 for RGB888. `de` is never high while `hs_n` is low.
- R5: A frame holds TOP_BLANK+ACT_LINES+BOT_BLANK lines. `vs_n` falls once every line period times that line count.
- R6: Each VS pulse holds `vs_n` low for VS_PIX*B clocks.
- R7: `de` is only high on lines TOP_BLANK through TOP_BLANK+ACT_LINES-1. The blanking lines before and after those lines carry no `de`, and a frame has ACT_LINES*ACT_PIX*B `de` cycles.
- R8: The first clock after `en` is sampled high, `vs_n` goes low while `hs_n` stays high. `hs_n` first falls VS_LEAD clocks later, which is the start of line 0, and `vs_n` is still low at that point.
- R9: Lowering `en` returns both syncs to 1, `de` to 0 and both counters to 0 on the next clock. Raising `en` again repeats the start-up order of R8.
- R10: `byte_idx` counts 0 to LINE_PIX*B-1, and it is 0 in the clock in which HS starts. `line_idx` steps by one at each line wrap and returns to 0 after the last line.
- R11: The format parameter sets B: 2 when PIX_FMT is PIX_RGB565 and 3 when it is PIX_RGB888.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the timers synchronously |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data-enable window for byte output |
| line_idx | output | LW | Current line within the frame, 0-based |
| byte_idx | output | BW | Current byte clock within the line, 0-based |

## Verification
The bench builds two instances side by side: one in RGB565 and one in RGB888. Both use a reduced geometry of 8 active pixels and 4 active lines, a 14-pixel line, a 2-pixel HS pulse, a 3-pixel lead, a 2-pixel VS pulse, and 2 blanking lines above and below the active lines. With this geometry a whole frame, including the wrap of the line counter, runs in a few hundred clocks for each format. The bench can then compare every output against a computed model on every cycle. The two formats give different pipeline delays and byte multipliers, which shows that the per-format scaling is correct. The bench also stops and restarts each instance in the middle of an active line, which exercises the clear-on-disable path and the start-up order again.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

  typedef enum logic {
    PIX_RGB565 = 1'b0,
    PIX_RGB888 = 1'b1
  } pix_fmt_e;

  function automatic int bytes_per_pix(input pix_fmt_e fmt);
    return (fmt == PIX_RGB888) ? 3 : 2;
  endfunction

  function automatic int pipe_dly(input pix_fmt_e fmt, input int d565, input int d888);
    return (fmt == PIX_RGB888) ? d888 : d565;
  endfunction

endpackage

// File: rtl/lcdt_launch.sv
module lcdt_launch #(
  parameter int LEAD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic v_go,
  output logic h_go
);
  localparam int CW = $clog2(LEAD + 1);

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_go     <= 1'b0;
      h_go     <= 1'b0;
      wait_cnt <= '0;
    end else if (!en) begin
      v_go     <= 1'b0;
      h_go     <= 1'b0;
      wait_cnt <= '0;
    end else begin
      v_go <= 1'b1;
      if (v_go && !h_go) begin
        if (wait_cnt == CW'(LEAD - 1)) h_go <= 1'b1;
        else wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // R8
  h_after_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_go |-> v_go);

  // R8
  h_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v_go) |-> !h_go);

endmodule

// File: rtl/lcdt_vtimer.sv
module lcdt_vtimer #(
  parameter int FRAME_CLK = 1008,
  parameter int VS_W      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run,
  output logic vs_n
);
  localparam int FW = $clog2(FRAME_CLK);
  localparam logic [FW-1:0] LAST_F = FW'(FRAME_CLK - 1);

  logic [FW-1:0] fcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (!en) fcnt <= '0;
    else if (run) fcnt <= (fcnt == LAST_F) ? '0 : fcnt + 1'b1;
  end

  assign vs_n = !(run && ({1'b0, fcnt} < (FW+1)'(VS_W)));

  // R5
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fcnt} < (FW+1)'(FRAME_CLK));

  // R6
  vs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vs_n) && en |=> !vs_n || !$past(en));

endmodule

// File: rtl/lcdt_htimer.sv
module lcdt_htimer #(
  parameter int LINE_CLK = 672,
  parameter int HS_W     = 4,
  parameter int DE_START = 17,
  parameter int DE_LEN   = 640,
  parameter int TOP      = 2,
  parameter int ACT      = 240,
  parameter int TOT      = 244,
  parameter int BW       = 10,
  parameter int LW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          run,
  output logic          hs_n,
  output logic          de,
  output logic [BW-1:0] bcnt,
  output logic [LW-1:0] lcnt
);
  localparam logic [BW-1:0] LAST_B = BW'(LINE_CLK - 1);
  localparam logic [LW-1:0] LAST_L = LW'(TOT - 1);
  localparam int            DE_END = DE_START + DE_LEN;

  logic col_ok, row_lo, row_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      lcnt <= '0;
    end else if (!en) begin
      bcnt <= '0;
      lcnt <= '0;
    end else if (run) begin
      if (bcnt == LAST_B) begin
        bcnt <= '0;
        lcnt <= (lcnt == LAST_L) ? '0 : lcnt + 1'b1;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  assign col_ok = ({1'b0, bcnt} >= (BW+1)'(DE_START)) && ({1'b0, bcnt} < (BW+1)'(DE_END));

  generate
    if (TOP == 0) begin : g_no_top
      assign row_lo = 1'b1;
    end else begin : g_top
      assign row_lo = ({1'b0, lcnt} >= (LW+1)'(TOP));
    end
  endgenerate

  assign row_hi = ({1'b0, lcnt} < (LW+1)'(TOP + ACT));
  assign de     = run && col_ok && row_lo && row_hi;
  assign hs_n   = !(run && ({1'b0, bcnt} < (BW+1)'(HS_W)));

  // R10
  byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, bcnt} < (BW+1)'(LINE_CLK));

  // R2
  line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && run && bcnt == LAST_B |=> bcnt == '0);

  // R4
  de_hs_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> hs_n);

  // R3
  hs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_n) && en |=> !hs_n || !$past(en));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen #(
  parameter lcdt_pkg::pix_fmt_e PIX_FMT = lcdt_pkg::PIX_RGB565,
  parameter int ACT_PIX    = 320,
  parameter int ACT_LINES  = 240,
  parameter int LINE_PIX   = 336,
  parameter int HS_PIX     = 2,
  parameter int LEAD_PIX   = 7,
  parameter int DLY_565    = 3,
  parameter int DLY_888    = 5,
  parameter int TOP_BLANK  = 2,
  parameter int BOT_BLANK  = 2,
  parameter int VS_PIX     = 2,
  parameter int VS_LEAD    = 1,
  localparam int BPP       = lcdt_pkg::bytes_per_pix(PIX_FMT),
  localparam int LINE_CLK  = LINE_PIX * BPP,
  localparam int TOT_LINES = TOP_BLANK + ACT_LINES + BOT_BLANK,
  localparam int BW        = $clog2(LINE_CLK),
  localparam int LW        = $clog2(TOT_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic          hs_n,
  output logic          vs_n,
  output logic          de,
  output logic [LW-1:0] line_idx,
  output logic [BW-1:0] byte_idx
);
  localparam int HS_W      = HS_PIX * BPP;
  localparam int VS_W      = VS_PIX * BPP;
  localparam int DE_START  = LEAD_PIX * BPP + lcdt_pkg::pipe_dly(PIX_FMT, DLY_565, DLY_888);
  localparam int DE_LEN    = ACT_PIX * BPP;
  localparam int FRAME_CLK = LINE_CLK * TOT_LINES;

  logic v_go, h_go;

  lcdt_launch #(.LEAD(VS_LEAD)) launch_i (
    .clk(clk), .rst_n(rst_n), .en(en), .v_go(v_go), .h_go(h_go)
  );

  lcdt_vtimer #(.FRAME_CLK(FRAME_CLK), .VS_W(VS_W)) vtim_i (
    .clk(clk), .rst_n(rst_n), .en(en), .run(v_go), .vs_n(vs_n)
  );

  lcdt_htimer #(
    .LINE_CLK(LINE_CLK), .HS_W(HS_W), .DE_START(DE_START), .DE_LEN(DE_LEN),
    .TOP(TOP_BLANK), .ACT(ACT_LINES), .TOT(TOT_LINES), .BW(BW), .LW(LW)
  ) htim_i (
    .clk(clk), .rst_n(rst_n), .en(en), .run(h_go),
    .hs_n(hs_n), .de(de), .bcnt(byte_idx), .lcnt(line_idx)
  );

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> hs_n && vs_n && !de && line_idx == '0 && byte_idx == '0);

  // R8
  hs_under_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_n) && line_idx == '0 |-> !vs_n);

  // R7
  de_off_vs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> vs_n);

endmodule

// File: tb/lcd_sync_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_sync_gen_tb_top;
  import lcdt_pkg::*;

  localparam int TP_ACT   = 8;
  localparam int TP_LINES = 4;
  localparam int TP_LINE  = 14;
  localparam int TP_HS    = 2;
  localparam int TP_LEAD  = 3;
  localparam int TP_TOP   = 2;
  localparam int TP_BOT   = 2;
  localparam int TP_VS    = 2;
  localparam int TP_TOT   = TP_TOP + TP_LINES + TP_BOT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic en_s [2];
  logic hs_w [2];
  logic vs_w [2];
  logic de_w [2];
  logic [4:0] by0;
  logic [5:0] by1;
  logic [2:0] ln0, ln1;
  int total = 0;
  int bad = 0;

  lcd_sync_gen #(
    .PIX_FMT(PIX_RGB565), .ACT_PIX(TP_ACT), .ACT_LINES(TP_LINES), .LINE_PIX(TP_LINE),
    .HS_PIX(TP_HS), .LEAD_PIX(TP_LEAD), .TOP_BLANK(TP_TOP), .BOT_BLANK(TP_BOT), .VS_PIX(TP_VS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en_s[0]), .hs_n(hs_w[0]), .vs_n(vs_w[0]),
    .de(de_w[0]), .line_idx(ln0), .byte_idx(by0)
  );

  lcd_sync_gen #(
    .PIX_FMT(PIX_RGB888), .ACT_PIX(TP_ACT), .ACT_LINES(TP_LINES), .LINE_PIX(TP_LINE),
    .HS_PIX(TP_HS), .LEAD_PIX(TP_LEAD), .TOP_BLANK(TP_TOP), .BOT_BLANK(TP_BOT), .VS_PIX(TP_VS)
  ) dut_j (
    .clk(clk), .rst_n(rst_n), .en(en_s[1]), .hs_n(hs_w[1]), .vs_n(vs_w[1]),
    .de(de_w[1]), .line_idx(ln1), .byte_idx(by1)
  );

  // R11: B = 2 for RGB565, 3 for RGB888; pipeline delay 3 or 5
  function automatic int bpp(input int d);
    return (d != 0) ? 3 : 2;
  endfunction
  function automatic int lclk(input int d);
    return TP_LINE * bpp(d);
  endfunction
  function automatic int dstart(input int d);
    return TP_LEAD * bpp(d) + ((d != 0) ? 5 : 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic grab(input int d, output int hs, output int vs, output int de, output int ln, output int by);
    hs = int'(hs_w[d]);
    vs = int'(vs_w[d]);
    de = int'(de_w[d]);
    ln = (d != 0) ? int'(ln1) : int'(ln0);
    by = (d != 0) ? int'(by1) : int'(by0);
  endtask

  // t = 0 is the first sample after en is taken high
  task automatic model(input int d, input int t, output int hs, output int vs, output int de,
                       output int ln, output int by);
    int lc, u;
    lc = lclk(d);
    vs = ((t % (lc * TP_TOT)) < TP_VS * bpp(d)) ? 0 : 1;
    if (t < 1) begin
      hs = 1; de = 0; ln = 0; by = 0;
    end else begin
      u  = t - 1;
      by = u % lc;
      ln = (u / lc) % TP_TOT;
      hs = (by < TP_HS * bpp(d)) ? 0 : 1;
      de = (by >= dstart(d) && by < dstart(d) + TP_ACT * bpp(d) &&
            ln >= TP_TOP && ln < TP_TOP + TP_LINES) ? 1 : 0;
    end
  endtask

  task automatic cmp_cycle(input int d, input int t);
    int ah, av, ad, al, ab, eh, ev, ed, el, eb;
    grab(d, ah, av, ad, al, ab);
    model(d, t, eh, ev, ed, el, eb);
    chk(ah == eh, "R3 hs_n", ah, eh);
    chk(av == ev, "R6 vs_n", av, ev);
    chk(ad == ed, "R4 de", ad, ed);
    chk(al == el, "R10 line_idx", al, el);
    chk(ab == eb, "R10 byte_idx", ab, eb);
  endtask

  task automatic chk_idle(input int d, input string tag);
    int h, v, e, l, b;
    grab(d, h, v, e, l, b);
    chk(h == 1, tag, h, 1);
    chk(v == 1, tag, v, 1);
    chk(e == 0, tag, e, 0);
    chk(l == 0, tag, l, 0);
    chk(b == 0, tag, b, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    en_s[0] = 1'b0;
    en_s[1] = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle(0, "R1 reset");
    chk_idle(1, "R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_idle(0, "R1 en low");
    chk_idle(1, "R1 en low");
  endtask

  task automatic t_frame(input int d);
    int lc, fr, h, v, e, l, b, ph, pv, pe;
    int f0, f1, hs_cnt, de_cnt, vs2, de_rise, run_len, run_max;
    lc = lclk(d); fr = lc * TP_TOT;
    f0 = -1; f1 = -1; hs_cnt = 0; de_cnt = 0; vs2 = -1; de_rise = -1;
    run_len = 0; run_max = 0; ph = 1; pv = 1; pe = 0;
    @(negedge clk);
    en_s[d] = 1'b1;
    for (int t = 0; t <= fr + lc; t++) begin
      @(negedge clk);
      cmp_cycle(d, t);
      chk_idle(1 - d, "R1 other idle");
      grab(d, h, v, e, l, b);
      if (t == 0) chk(h == 1 && v == 0, "R8 vs first", h, 1);
      if (ph == 1 && h == 0) begin
        if (f0 < 0) f0 = t; else if (f1 < 0) f1 = t;
        if (t >= 1 && t < 1 + fr) hs_cnt++;
      end
      if (pv == 1 && v == 0 && t > 0 && vs2 < 0) vs2 = t;
      if (e == 1 && t < 1 + fr) de_cnt++;
      if (pe == 0 && e == 1 && de_rise < 0) de_rise = t;
      run_len = (e == 1) ? run_len + 1 : 0;
      if (run_len > run_max) run_max = run_len;
      ph = h; pv = v; pe = e;
    end
    chk(f0 == 1, "R8 hs lead", f0, 1);
    chk(f1 - f0 == lc, "R2 line period", f1 - f0, lc);
    chk(hs_cnt == TP_TOT, "R5 lines per frame", hs_cnt, TP_TOT);
    chk(vs2 == fr, "R5 frame period", vs2, fr);
    chk(de_cnt == TP_LINES * TP_ACT * bpp(d), "R7 de per frame", de_cnt, TP_LINES * TP_ACT * bpp(d));
    chk(de_rise == 1 + TP_TOP * lc + dstart(d), "R4 first byte", de_rise, 1 + TP_TOP * lc + dstart(d));
    chk(run_max == TP_ACT * bpp(d), "R11 de run", run_max, TP_ACT * bpp(d));
    en_s[d] = 1'b0;
    repeat (2) @(negedge clk);
    chk_idle(d, "R9 after frame");
  endtask

  task automatic t_stop(input int d);
    int lc, stop_t, h, v, e, l, b;
    lc = lclk(d);
    stop_t = 1 + 2 * lc + dstart(d) + 2;
    @(negedge clk);
    en_s[d] = 1'b1;
    for (int t = 0; t <= stop_t; t++) begin
      @(negedge clk);
      cmp_cycle(d, t);
    end
    grab(d, h, v, e, l, b);
    chk(e == 1, "R9 de before stop", e, 1);
    en_s[d] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk_idle(d, "R9 stopped");
    end
    en_s[d] = 1'b1;
    for (int t = 0; t <= 2 * lc; t++) begin
      @(negedge clk);
      cmp_cycle(d, t);
      grab(d, h, v, e, l, b);
      if (t == 0) chk(h == 1 && v == 0, "R8 restart vs first", v, 0);
      if (t == 1) chk(h == 0 && v == 0, "R8 restart hs", h, 0);
    end
    en_s[d] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    en_s[0] = 1'b0;
    en_s[1] = 1'b0;
    fork
      begin
        t_reset();
        t_frame(0);
        t_frame(1);
        t_stop(0);
        t_stop(1);
      end
      begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule